// File: doc/BRIEF.md
# Maskable Read-to-Clear Interrupt Controller

This block collects up to sixteen single-cycle event pulses from a small peripheral and turns them into one active-low interrupt request. The events arrive as two groups of eight. Each pulse sets a sticky status bit. Each status bit has its own enable bit, and only enabled bits can pull the request line low. A bit whose enable is clear is still recorded, and software can read it at any time.

A host reaches the block through a plain synchronous register port. The port has an address, a read strobe, a write strobe, write data and registered read data. Through it the host sees two status registers, two enable registers and a version register.

Reading a status register returns its contents and clears the enabled bits in it. That read also releases the request line. The line stays released until an enabled status bit newly becomes active.

Top module: `irq_aggregator`

## Requirements
- R1: After reset `irq_n` is 1, both status registers read 00h, the enable register at 05h reads 00h, and the enable register at 06h reads 01h.
- R2: A pulse on `evt_i[i]` sets status bit i. Bits 7:0 of `evt_i` map to bits 7:0 of the register at 03h. Bits 15:8 map to bits 7:0 of the register at 04h. Only implemented positions latch: 03h uses mask DFh (bit 5 reserved) and 04h uses mask EFh (bit 4 reserved). Reserved positions read 0.
- R3: When an event pulse sets a bit whose enable is set, `irq_n` goes low in the second cycle after the pulse cycle.
- R4: An event whose enable is clear still latches into status, and `irq_n` stays high.
- R5: A read strobe returns the register value on `reg_rdata` in the following cycle. A read of 03h or 04h clears only the bits of that register whose enable is set. Bits whose enable is clear keep their value.
- R6: `irq_n` returns to 1 in the cycle after any status read. It stays high while the set of enabled active status bits gains no new member.
- R7: If an event pulse coincides with a clearing read of its register, the read returns the value before the event, and the bit is set afterwards.
- R8: Writing an enable bit to 1 while its status bit is already set drives `irq_n` low in the second cycle after the write cycle.
- R9: Writes to 05h and 06h load the enable registers, masked to DFh and EFh respectively. Writes to 01h, 03h and 04h change nothing.
- R10: A read of 01h returns bits 7:5 as 0 and the `VERSION` parameter in bits 4:0 (default 0). A read of an unmapped address returns 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 16 | Event pulses; [7:0] first group, [15:8] second group, bit 8 is the power-on event |
| reg_addr | input | 8 | Register address |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Each result falls due a fixed number of cycles after its stimulus:

- Status and enable values are visible one cycle after an event pulse or a write.
- Read data appears one cycle after the read strobe.
- `irq_n` goes low two cycles after an enabling event or write.
- `irq_n` goes high one cycle after a status read.

The bench drives every input on the falling edge and samples on a later falling edge. It counts out exactly these cycles before each compare, so every check lands in its due cycle. Where a result must not appear, such as a masked event or a partial release, the line is checked again after several more cycles.

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter logic [4:0] VERSION  = 5'd0,
  parameter logic [7:0] IMPL_A   = 8'hDF,
  parameter logic [7:0] IMPL_B   = 8'hEF,
  parameter logic [7:0] EN_B_RST = 8'h01,
  parameter int         AW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [15:0]   evt_i,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_rd,
  input  logic          reg_wr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          irq_n
);

  localparam logic [AW-1:0] A_VER  = AW'(1);
  localparam logic [AW-1:0] A_STA  = AW'(3);
  localparam logic [AW-1:0] A_STB  = AW'(4);
  localparam logic [AW-1:0] A_ENA  = AW'(5);
  localparam logic [AW-1:0] A_ENB  = AW'(6);
  localparam logic [7:0]    EN_B0  = EN_B_RST & IMPL_B;

  logic [7:0]  st_a, st_b, en_a, en_b;
  logic [15:0] act, act_q;
  logic        irq_q;

  wire rd_sa = reg_rd && (reg_addr == A_STA);
  wire rd_sb = reg_rd && (reg_addr == A_STB);
  wire [7:0] clr_a = rd_sa ? en_a : 8'h00;
  wire [7:0] clr_b = rd_sb ? en_b : 8'h00;

  assign act = {st_b & en_b, st_a & en_a};
  wire fresh = |(act & ~act_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_a <= 8'h00;
      st_b <= 8'h00;
    end else begin
      st_a <= (st_a & ~clr_a) | (evt_i[7:0]  & IMPL_A);
      st_b <= (st_b & ~clr_b) | (evt_i[15:8] & IMPL_B);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_a <= 8'h00;
      en_b <= EN_B0;
    end else if (reg_wr) begin
      if (reg_addr == A_ENA) en_a <= reg_wdata & IMPL_A;
      if (reg_addr == A_ENB) en_b <= reg_wdata & IMPL_B;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      irq_q <= 1'b0;
    end else begin
      act_q <= act;
      if (fresh)              irq_q <= 1'b1;
      else if (rd_sa || rd_sb) irq_q <= 1'b0;
    end
  end

  assign irq_n = ~irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_rdata <= 8'h00;
    else if (reg_rd) begin
      case (reg_addr)
        A_VER:   reg_rdata <= {3'b000, VERSION};
        A_STA:   reg_rdata <= st_a;
        A_STB:   reg_rdata <= st_b;
        A_ENA:   reg_rdata <= en_a;
        A_ENB:   reg_rdata <= en_b;
        default: reg_rdata <= 8'h00;
      endcase
    end
  end

  assert_evt_latched_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (({st_b, st_a} & $past(evt_i & {IMPL_B, IMPL_A})) == $past(evt_i & {IMPL_B, IMPL_A})));

  assert_masked_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sa |=> ((st_a & $past(st_a & ~en_a)) == $past(st_a & ~en_a)));

  assert_enabled_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sa && evt_i[7:0] == 8'h00) |=> ((st_a & $past(en_a)) == 8'h00));

  assert_release_on_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_sa || rd_sb) && !fresh) |=> irq_n);

  assert_enabled_event_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fresh |=> !irq_n);

  assert_status_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_rd && reg_addr == A_STA && evt_i[7:0] == 8'h00) |=> $stable(st_a));

endmodule

// File: tb/sim_irq_aggregator.sv
module sim_irq_aggregator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] evt_i = '0;
  logic [7:0]  reg_addr = '0;
  logic        reg_rd = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        irq_n;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  irq_aggregator u0 (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_addr(reg_addr),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_n(irq_n)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] v);
    @(negedge clk); reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic pulse(input logic [15:0] e);
    @(negedge clk); evt_i = e;
    @(negedge clk); evt_i = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check("R1 irq_n", {7'b0, irq_n}, 8'h01);
    rd(8'h05, d); check("R1 en 05h", d, 8'h00);
    rd(8'h06, d); check("R1 en 06h", d, 8'h01);
    rd(8'h03, d); check("R1 st 03h", d, 8'h00);
    rd(8'h04, d); check("R1 st 04h", d, 8'h00);
    rd(8'h01, d); check("R10 version", d, 8'h00);
    rd(8'h02, d); check("R10 unmapped", d, 8'h00);
  endtask

  task automatic t_por;
    logic [7:0] d;
    pulse(16'h0100);
    check("R3 irq not yet", {7'b0, irq_n}, 8'h01);
    @(negedge clk);
    check("R3 irq low", {7'b0, irq_n}, 8'h00);
    rd(8'h04, d);
    check("R5 por read", d, 8'h01);
    check("R6 irq released", {7'b0, irq_n}, 8'h01);
    rd(8'h04, d);
    check("R5 por cleared", d, 8'h00);
  endtask

  task automatic t_masked;
    logic [7:0] d;
    pulse(16'h0001);
    idle(3);
    check("R4 irq stays high", {7'b0, irq_n}, 8'h01);
    rd(8'h03, d); check("R4 latched", d, 8'h01);
    rd(8'h03, d); check("R5 disabled kept", d, 8'h01);
  endtask

  task automatic t_enable_latched;
    logic [7:0] d;
    wr(8'h05, 8'h01);
    @(negedge clk);
    check("R8 irq after enable", {7'b0, irq_n}, 8'h00);
    rd(8'h03, d); check("R8 read", d, 8'h01);
    check("R6 release", {7'b0, irq_n}, 8'h01);
    rd(8'h03, d); check("R5 enabled cleared", d, 8'h00);
  endtask

  task automatic t_reserved;
    logic [7:0] d;
    wr(8'h05, 8'hFF); rd(8'h05, d); check("R9 en 05h mask", d, 8'hDF);
    wr(8'h06, 8'hFF); rd(8'h06, d); check("R9 en 06h mask", d, 8'hEF);
    pulse(16'h1020);
    idle(2);
    check("R2 reserved no irq", {7'b0, irq_n}, 8'h01);
    rd(8'h03, d); check("R2 reserved 03h", d, 8'h00);
    rd(8'h04, d); check("R2 reserved 04h", d, 8'h00);
    wr(8'h03, 8'hFF); wr(8'h04, 8'hFF); wr(8'h01, 8'hFF);
    rd(8'h03, d); check("R9 write 03h ignored", d, 8'h00);
    rd(8'h04, d); check("R9 write 04h ignored", d, 8'h00);
    rd(8'h01, d); check("R9 write 01h ignored", d, 8'h00);
    pulse(16'h8080);
    rd(8'h03, d); check("R2 group A bit7", d, 8'h80);
    rd(8'h04, d); check("R2 group B bit7", d, 8'h80);
    idle(1);
  endtask

  task automatic t_coincide;
    logic [7:0] d;
    pulse(16'h0002);
    @(negedge clk);
    check("R3 irq low", {7'b0, irq_n}, 8'h00);
    @(negedge clk); reg_addr = 8'h03; reg_rd = 1'b1; evt_i = 16'h0004;
    @(negedge clk); reg_rd = 1'b0; evt_i = '0; d = reg_rdata;
    check("R7 pre-event data", d, 8'h02);
    check("R6 release", {7'b0, irq_n}, 8'h01);
    @(negedge clk);
    check("R7 new event irq", {7'b0, irq_n}, 8'h00);
    rd(8'h03, d); check("R7 bit kept", d, 8'h04);
  endtask

  task automatic t_partial;
    logic [7:0] d;
    pulse(16'h0202);
    @(negedge clk);
    check("R3 irq low both", {7'b0, irq_n}, 8'h00);
    rd(8'h03, d); check("R5 group A", d, 8'h02);
    check("R6 release partial", {7'b0, irq_n}, 8'h01);
    idle(4);
    check("R6 stays high", {7'b0, irq_n}, 8'h01);
    rd(8'h04, d); check("R5 group B", d, 8'h02);
    rd(8'h04, d); check("R5 group B cleared", d, 8'h00);
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_por;
    t_masked;
    t_enable_latched;
    t_reserved;
    t_coincide;
    t_partial;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule